// File: doc/BRIEF.md
# PWM Event Interrupt and Trigger Unit

This unit sits beside the counter of one PWM generator. It compares the counter value against zero, against the load value and against two comparators, and it produces six counter events. Each comparator match counts only when the count direction agrees, so every comparator yields one rising-count event and one falling-count event. A single enable register routes any mix of the six events to two independent destinations: a one-cycle ADC trigger pulse, and a set of sticky interrupt status bits whose OR forms the interrupt line.

An event is recognised in the cycle in which its condition becomes true. A counter that rests on a matching value therefore produces one event, not a stream of them. Software programs the enables and clears the status through a small write port with one select bit. A read port with one select bit returns either the enable register or the status.

Top module: `pwm_evt_irq_trig`

## Requirements
- R1: After reset the enable register reads 0, the status reads 0, and trig_o and irq_o are low.
- R2: The zero event (index 0) occurs when cnt_val becomes 0. The load event (index 1) occurs when cnt_val becomes equal to load_val. Both are independent of direction.
- R3: cnt_down=0 means counting up and cnt_down=1 means counting down. A cmp_a match is event 2 when counting up and event 3 when counting down. A cmp_b match is event 4 when counting up and event 5 when counting down.
- R4: A write with wr_sel=0 loads the enable register. Bits 5:0 of that register enable the interrupt status for events 0 to 5, bit n for event n. A status bit can be set only if its enable was set.
- R5: Bits 13:8 enable the trigger for events 0 to 5, bit 8+n for event n. Bits 7:6 and 31:14 ignore writes and read as 0.
- R6: trig_o is high for exactly the cycle after the clock edge at which at least one trigger-enabled event occurred. It is the OR of all trigger-enabled events.
- R7: An event fires only at the edge where its condition changes from false to true. A condition that stays true produces no further events.
- R8: Status bits are sticky. A write with wr_sel=1 clears each status bit whose wr_data bit (5:0) is 1. A new event on a bit in the same cycle wins over the clear. irq_o is the OR of the status bits.
- R9: Events whose conditions become true in the same cycle, such as zero and a comparator at 0, are all reported in that cycle.
- R10: rd_data is combinational. With rd_sel=0 it returns the enable register. With rd_sel=1 it returns the status in bits 5:0, with all higher bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | CNT_W | Current PWM counter value |
| cnt_down | input | 1 | Count direction, 1 = counting down |
| load_val | input | CNT_W | Counter load value |
| cmp_a | input | CNT_W | Comparator A value |
| cmp_b | input | CNT_W | Comparator B value |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = write enables, 1 = write-one-to-clear status |
| wr_data | input | REG_W | Write data |
| rd_sel | input | 1 | 0 = read enables, 1 = read status |
| rd_data | output | REG_W | Read data |
| trig_o | output | 1 | One-cycle ADC trigger pulse |
| raw_sts | output | 6 | Sticky interrupt status |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench uses the defaults CNT_W=16 and REG_W=32, with a load value of 10, so a full up-and-down sweep of the counter takes only a few dozen cycles. These values bring every event into reach: the direction split on both comparators, a comparator moved to zero so that it coincides with the zero event, a counter held on a matching value, and a clear that collides with a new event. All-ones writes with a 32-bit register exercise every reserved bit.

// File: rtl/pwm_evt_pkg.sv
package pwm_evt_pkg;
  localparam int NUM_EVT  = 6;
  localparam int TRIG_LSB = 8;

  typedef enum int unsigned {
    EV_ZERO = 0,
    EV_LOAD = 1,
    EV_AUP  = 2,
    EV_ADN  = 3,
    EV_BUP  = 4,
    EV_BDN  = 5
  } evt_idx_e;

  typedef logic [NUM_EVT-1:0] evt_vec_t;
endpackage

// File: rtl/pwm_evt_detect.sv
module pwm_evt_detect
  import pwm_evt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_down,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  output evt_vec_t         evt_new
);
  localparam int NUM_CMP = 2;

  evt_vec_t cond_c;
  evt_vec_t cond_q, cond_d;
  logic     started_q, started_d;
  logic [CNT_W-1:0] cmp_val [NUM_CMP];

  assign cmp_val[0] = cmp_a;
  assign cmp_val[1] = cmp_b;

  assign cond_c[EV_ZERO] = (cnt_val == '0);
  assign cond_c[EV_LOAD] = (cnt_val == load_val);

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    logic hit;
    assign hit                    = (cnt_val == cmp_val[g]);
    assign cond_c[EV_AUP + 2*g]   = hit && !cnt_down;
    assign cond_c[EV_ADN + 2*g]   = hit &&  cnt_down;
  end

  assign evt_new = cond_c & ~cond_q;

  always_comb begin
    cond_d    = cond_c;
    started_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q    <= '0;
      started_q <= 1'b0;
    end else begin
      cond_q    <= cond_d;
      started_q <= started_d;
    end
  end

  // R7: inputs unchanged since last edge -> no new event
  a_r7_quiet_when_held: assert property (@(posedge clk) disable iff (!rst_n)
    (started_q && $stable(cnt_val) && $stable(cnt_down) && $stable(load_val) &&
     $stable(cmp_a) && $stable(cmp_b)) |-> (evt_new == '0));
endmodule

// File: rtl/pwm_evt_regs.sv
module pwm_evt_regs
  import pwm_evt_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_sel,
  input  evt_vec_t         evt_new,
  output evt_vec_t         int_en,
  output evt_vec_t         trig_en,
  output evt_vec_t         sts,
  output logic [REG_W-1:0] rd_data
);
  localparam logic [REG_W-1:0] FIELD_ONES = (REG_W'(1) << NUM_EVT) - REG_W'(1);
  localparam logic [REG_W-1:0] EN_MASK    = FIELD_ONES | (FIELD_ONES << TRIG_LSB);

  logic [REG_W-1:0] en_q, en_d;
  evt_vec_t         sts_q, sts_d;
  logic             en_we, clr_we;
  evt_vec_t         clr_bits;

  assign en_we    = wr_en && !wr_sel;
  assign clr_we   = wr_en &&  wr_sel;
  assign clr_bits = clr_we ? wr_data[NUM_EVT-1:0] : '0;

  always_comb begin
    en_d = en_q;
    if (en_we) en_d = wr_data & EN_MASK;
  end

  always_comb begin
    sts_d = (sts_q & ~clr_bits) | (evt_new & int_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      sts_q <= '0;
    end else begin
      en_q  <= en_d;
      sts_q <= sts_d;
    end
  end

  assign int_en  = en_q[NUM_EVT-1:0];
  assign trig_en = en_q[TRIG_LSB +: NUM_EVT];
  assign sts     = sts_q;

  always_comb begin
    if (rd_sel) rd_data = REG_W'(sts_q);
    else        rd_data = en_q;
  end

  // R5: reserved enable bits stay zero
  a_r5_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q & ~EN_MASK) == '0);

  // R8: without a clear, no status bit falls
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((sts_q & $past(sts_q)) == $past(sts_q)));

  // R8: a clear with no colliding event empties the chosen bits
  a_r8_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && evt_new == '0) |=> ((sts_q & $past(wr_data[NUM_EVT-1:0])) == '0));
endmodule

// File: rtl/pwm_evt_trig.sv
module pwm_evt_trig
  import pwm_evt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  evt_vec_t evt_new,
  input  evt_vec_t trig_en,
  output logic     trig_o
);
  logic trig_q, trig_d;

  always_comb begin
    trig_d = |(evt_new & trig_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_d;
  end

  assign trig_o = trig_q;
endmodule

// File: rtl/pwm_evt_irq_trig.sv
module pwm_evt_irq_trig
  import pwm_evt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int REG_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   cnt_val,
  input  logic               cnt_down,
  input  logic [CNT_W-1:0]   load_val,
  input  logic [CNT_W-1:0]   cmp_a,
  input  logic [CNT_W-1:0]   cmp_b,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               rd_sel,
  output logic [REG_W-1:0]   rd_data,
  output logic               trig_o,
  output logic [NUM_EVT-1:0] raw_sts,
  output logic               irq_o
);
  evt_vec_t evt_new, int_en, trig_en, sts;

  pwm_evt_detect #(.CNT_W(CNT_W)) u_detect (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_down(cnt_down),
    .load_val(load_val), .cmp_a(cmp_a), .cmp_b(cmp_b), .evt_new(evt_new)
  );

  pwm_evt_regs #(.REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .evt_new(evt_new), .int_en(int_en), .trig_en(trig_en),
    .sts(sts), .rd_data(rd_data)
  );

  pwm_evt_trig u_trig (
    .clk(clk), .rst_n(rst_n), .evt_new(evt_new), .trig_en(trig_en), .trig_o(trig_o)
  );

  assign raw_sts = sts;
  assign irq_o   = |sts;

  // R4: a status bit may rise only if its interrupt enable was set
  a_r4_sts_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    (sts & ~$past(sts) & ~$past(int_en)) == '0);

  // R6: a trigger pulse requires some trigger enable in the prior cycle
  a_r6_trig_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> ($past(trig_en) != '0));
endmodule

// File: tb/pwm_evt_irq_trig_bench.sv
module pwm_evt_irq_trig_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;
  localparam int RW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] cnt_val, load_val, cmp_a, cmp_b;
  logic          cnt_down, wr_en, wr_sel, rd_sel;
  logic [RW-1:0] wr_data, rd_data;
  logic          trig_o, irq_o;
  logic [5:0]    raw_sts;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_evt_irq_trig #(.CNT_W(CW), .REG_W(RW)) u_pwm_evt_irq_trig (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_down(cnt_down),
    .load_val(load_val), .cmp_a(cmp_a), .cmp_b(cmp_b), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .trig_o(trig_o), .raw_sts(raw_sts), .irq_o(irq_o)
  );

  typedef struct {
    int         due;
    logic       trig;
    logic [5:0] sts;
    string      tag;
  } exp_t;

  exp_t       sb[$];
  int         cyc = 0;
  int         checks = 0;
  int         fails = 0;
  logic [31:0] m_en = '0;
  logic [5:0]  m_sts = '0;
  logic [5:0]  m_prev = '0;
  logic [CW-1:0] cur_cnt = 1;
  logic          cur_dn = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares scoreboard entries once their edge has passed
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      chk({e.tag, " trig"}, 32'(trig_o), 32'(e.trig));
      chk({e.tag, " sts"}, 32'(raw_sts), 32'(e.sts));
      chk({e.tag, " irq"}, 32'(irq_o), 32'(|e.sts));
    end
  end

  // driver: applies one cycle of stimulus and predicts the outcome
  task automatic step(input logic [CW-1:0] c, input logic dn, input logic w,
                      input logic ws, input logic [31:0] wd, input string tag);
    logic [5:0] cond, evt, clr;
    exp_t e;
    @(negedge clk);
    cnt_val = c; cnt_down = dn; wr_en = w; wr_sel = ws; wr_data = wd;
    cur_cnt = c; cur_dn = dn;
    cond[0] = (c == 0);
    cond[1] = (c == load_val);
    cond[2] = (c == cmp_a) && !dn;
    cond[3] = (c == cmp_a) &&  dn;
    cond[4] = (c == cmp_b) && !dn;
    cond[5] = (c == cmp_b) &&  dn;
    evt    = cond & ~m_prev;
    m_prev = cond;
    clr    = (w && ws) ? wd[5:0] : 6'h0;
    e.trig = |(evt & m_en[13:8]);
    m_sts  = (m_sts & ~clr) | (evt & m_en[5:0]);
    e.sts  = m_sts;
    e.due  = cyc + 1;
    e.tag  = tag;
    if (w && !ws) m_en = wd & 32'h0000_3F3F;
    sb.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(cur_cnt, cur_dn, 1'b0, 1'b0, 32'h0, tag);
  endtask

  task automatic ramp(input int from, input int to, input logic dn, input string tag);
    if (from <= to) for (int i = from; i <= to; i++) step(CW'(i), dn, 1'b0, 1'b0, 32'h0, tag);
    else            for (int i = from; i >= to; i--) step(CW'(i), dn, 1'b0, 1'b0, 32'h0, tag);
  endtask

  task automatic rd_check(input logic sel, input logic [31:0] exp, input string tag);
    idle(tag);
    rd_sel = sel;
    #1;
    chk({tag, " rd_data"}, rd_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cnt_val = 1; cnt_down = 0; load_val = 10; cmp_a = 4; cmp_b = 7;
    wr_en = 0; wr_sel = 0; wr_data = 0; rd_sel = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1 chk("R1 enable reset", rd_data, 32'h0);
    rd_sel = 1; #1 chk("R1 status reset", rd_data, 32'h0);
    chk("R1 trig reset", 32'(trig_o), 32'h0);
    chk("R1 irq reset", 32'(irq_o), 32'h0);
    rst_n = 1'b1;

    // R5 / R10: reserved bits masked on write and read
    step(1, 0, 1, 0, 32'hFFFF_FFFF, "R5 write all ones");
    rd_check(0, 32'h0000_3F3F, "R5 R10 enable readback");
    rd_check(1, 32'h0000_0000, "R10 status readback");

    // R2 / R7: zero event, interrupt only, counter held on zero
    step(1, 1, 1, 0, 32'h0000_0001, "R4 enable zero irq");
    step(1, 1, 1, 1, 32'h0000_003F, "R8 clear all");
    ramp(3, 0, 1, "R2 ramp to zero");
    step(0, 1, 0, 0, 0, "R7 hold zero");
    step(0, 1, 0, 0, 0, "R7 hold zero");
    step(1, 0, 0, 0, 0, "R2 leave zero");
    rd_check(1, 32'h0000_0001, "R2 R10 zero status");
    step(1, 0, 1, 1, 32'h0000_0001, "R8 clear zero");
    rd_check(1, 32'h0000_0000, "R8 cleared");

    // R3: trigger on A-down only (bit 11)
    step(1, 0, 1, 0, 32'h0000_0800, "R5 enable A-down trig");
    ramp(1, 10, 0, "R3 up past A");
    ramp(9, 1, 1, "R3 R6 down past A");

    // R4: B-up interrupt only (bit 4)
    step(1, 0, 1, 0, 32'h0000_0010, "R4 enable B-up irq");
    ramp(2, 10, 0, "R4 up past B");
    ramp(9, 2, 1, "R4 down past B");
    rd_check(1, 32'h0000_0010, "R4 B-up status");

    // R6 / R7: everything enabled, full sweep, hold on B match
    step(2, 1, 1, 1, 32'h0000_003F, "R8 clear all");
    step(2, 1, 1, 0, 32'h0000_3F3F, "R6 enable all");
    ramp(1, 0, 1, "R6 down to zero");
    ramp(1, 7, 0, "R6 up to B");
    step(7, 0, 0, 0, 0, "R7 hold B");
    step(7, 0, 0, 0, 0, "R7 hold B");
    step(7, 1, 0, 0, 0, "R3 direction flip on B");
    ramp(8, 10, 0, "R6 up to load");
    ramp(9, 1, 1, "R6 sweep down");

    // R9: comparator A at zero coincides with zero event
    step(1, 1, 1, 1, 32'h0000_003F, "R8 clear all");
    cmp_a = 0;
    step(1, 1, 0, 0, 0, "R9 move A");
    step(0, 1, 0, 0, 0, "R9 zero and A-down");
    rd_check(1, 32'h0000_0009, "R9 both bits");

    // R8: clear colliding with a new load event, set wins
    ramp(1, 9, 0, "R8 climb");
    step(10, 0, 1, 1, 32'h0000_003F, "R8 clear vs load");
    rd_check(1, 32'h0000_0002, "R8 set wins");

    repeat (3) idle("drain");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule